// File: doc/BRIEF.md
# Flash Page-Load Buffer Controller

This block manages the loading phase of a page write in a parallel flash array. The command decoder upstream recognises the three-write page-program unlock sequence and gives a one-cycle arm pulse. The controller then opens a load window and accepts word writes into a 64-word page buffer. The word offset comes from the low address bits and the page address from the upper bits. Words may arrive in any order. A later write to an offset that was already loaded replaces the earlier value.

The window stays open while writes keep arriving. Each accepted word restarts a timeout that counts a one-microsecond tick. When the timeout expires, the controller gives a one-cycle program-start pulse together with the latched page address. It then holds busy until the programming engine reports done. During that time the engine reads the page through a combinational read port. Offsets that were never loaded read back as all ones, which is the erased value.

Writes use a valid/ready handshake. A word transfers on a clock edge where wr_valid_i and wr_ready_o are both high. Ready is high only while the load window is open. In idle and while programming, ready is low. A source that holds valid during those times is stalled: its word is not stored and it does not reach the engine.

Top module: `pgload_ctrl`

## Requirements
- R1: Before an arm pulse is seen in idle, wr_ready_o stays low. A write offered at that time is never stored and cannot start programming.
- R2: An arm pulse in idle opens the load window and raises wr_ready_o on the next cycle. An arm pulse while the window is open or while programming has no effect: loaded words are kept and the window stays as it was.
- R3: An accepted write stores its data at the buffer entry given by address bits 5:0. Bits 19:6 are the page address.
- R4: Words may be loaded in any offset order. Each is found at its own offset when the page is handed over.
- R5: Every offset not written in the current window reads as 16'hFFFF on the engine read port. The buffer is blanked when a window opens.
- R6: Two accepted writes to the same offset leave the later data in the buffer.
- R7: The page address of the first accepted write is latched and appears on prog_page_o with the program-start pulse.
- R8: After the first write, a write whose bits 19:6 differ from the latched page is accepted by the handshake, but its data is discarded and it does not restart the timeout. It sets page_err_o, which stays high until the next window opens.
- R9: The window closes when TIMEOUT_TICKS ticks have been counted since the last accepted same-page write. prog_start_o is high on the cycle after the edge that carried the last of those ticks.
- R10: prog_start_o is a single-cycle pulse. busy_o rises with it and stays high until an edge where eng_done_i is high.
- R11: A window that times out with no accepted write returns to idle without a program-start pulse.
- R12: wr_ready_o is low while busy_o is high. A write held valid during programming is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse: page-program command decoded |
| wr_valid_i | input | 1 | Write word offered |
| wr_ready_o | output | 1 | Load window open; word accepted when valid is also high |
| wr_addr_i | input | 20 | Write address: bits 19:6 page, bits 5:0 offset |
| wr_data_i | input | 16 | Write data |
| tick_us_i | input | 1 | One-cycle microsecond tick |
| rd_idx_i | input | 6 | Engine read offset |
| rd_data_o | output | 16 | Buffer word at rd_idx_i, all ones if not loaded |
| prog_start_o | output | 1 | One-cycle program-start pulse |
| prog_page_o | output | 14 | Latched page address |
| busy_o | output | 1 | Programming in progress |
| eng_done_i | input | 1 | Engine finished programming |
| page_err_o | output | 1 | Sticky flag: a write for a different page was seen in the window |

## Verification
The assertions assume the following about the inputs:
- arm_i and eng_done_i are single-cycle pulses, and eng_done_i comes only while busy is high.
- tick_us_i is high for one cycle at a time.
- A writer holds wr_valid_i and its address and data steady until the word transfers.

The stimulus keeps to these rules:
- Every input changes on the falling clock edge.
- The tick is generated every third cycle.
- The engine model raises done a few cycles after the start pulse.
- Writes are offered only through a task that waits for ready before dropping valid.

Stalled writes are still offered, with valid held high while ready is low, to exercise back-pressure.

// File: rtl/pgl_pkg.sv
package pgl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgl_state_e;
endpackage

// File: rtl/pgl_timer.sv
module pgl_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || !run)  cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !restart && tick && (cnt_q == CW'(LIMIT - 1));

  // R9: count never passes the limit while the window is open
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(LIMIT)));
  // R9: a restart brings the count back to zero
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/pgl_buffer.sv
module pgl_buffer #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  localparam int IW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic hit;
    assign hit = we && (waddr == IW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q[gi] <= 1'b0;
      else if (clear) vld_q[gi] <= 1'b0;
      else if (hit)   vld_q[gi] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) mem_q[gi] <= wdata;
    end
  end

  assign rdata = vld_q[raddr] ? mem_q[raddr] : {DATA_W{1'b1}};

  // R3: a write marks its own entry as loaded
  p_write_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clear) |=> vld_q[$past(waddr)]);
  // R5: opening a window blanks every entry
  p_clear_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld_q == '0));
endmodule

// File: rtl/pgload_ctrl.sv
module pgload_ctrl #(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int OFF_W         = 6,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm_i,
  input  logic                    wr_valid_i,
  output logic                    wr_ready_o,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    tick_us_i,
  input  logic [OFF_W-1:0]        rd_idx_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    prog_start_o,
  output logic [ADDR_W-OFF_W-1:0] prog_page_o,
  output logic                    busy_o,
  input  logic                    eng_done_i,
  output logic                    page_err_o
);
  import pgl_pkg::*;

  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << OFF_W;

  pgl_state_e        st_q;
  logic              got_any_q;
  logic              err_q;
  logic              start_q;
  logic [PAGE_W-1:0] page_q;

  logic [PAGE_W-1:0] page_in;
  logic              fire, page_ok, good, bad, open_win, expire;

  assign page_in  = wr_addr_i[ADDR_W-1:OFF_W];
  assign fire     = wr_valid_i && wr_ready_o;
  assign page_ok  = !got_any_q || (page_in == page_q);
  assign good     = fire && page_ok;
  assign bad      = fire && !page_ok;
  assign open_win = (st_q == ST_IDLE) && arm_i;

  pgl_timer #(.LIMIT(TIMEOUT_TICKS)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st_q == ST_LOAD),
    .restart(good),
    .tick   (tick_us_i),
    .expire (expire)
  );

  pgl_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(open_win),
    .we   (good),
    .waddr(wr_addr_i[OFF_W-1:0]),
    .wdata(wr_data_i),
    .raddr(rd_idx_i),
    .rdata(rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      got_any_q <= 1'b0;
      err_q     <= 1'b0;
      start_q   <= 1'b0;
      page_q    <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (arm_i) begin
            st_q      <= ST_LOAD;
            got_any_q <= 1'b0;
            err_q     <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (good) begin
            got_any_q <= 1'b1;
            if (!got_any_q) page_q <= page_in;
          end
          if (bad) err_q <= 1'b1;
          if (expire) begin
            if (got_any_q) begin
              st_q    <= ST_PROG;
              start_q <= 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_PROG: begin
          if (eng_done_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_ready_o   = (st_q == ST_LOAD);
  assign busy_o       = (st_q == ST_PROG);
  assign prog_start_o = start_q;
  assign prog_page_o  = page_q;
  assign page_err_o   = err_q;

  // R10: start is a single-cycle pulse
  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> !prog_start_o);
  // R10: busy holds until the engine reports done
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !eng_done_i) |=> busy_o);
  // R7: once latched, the page does not move during the window
  p_page_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && got_any_q) |=> (prog_page_o == $past(prog_page_o)));
  // R8: the error flag is sticky until a new window opens
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_err_o && !open_win) |=> page_err_o);
  // R11: a start only follows a window that loaded something
  p_start_loaded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> prog_start_o);
  // R12: no transfer can happen while programming
  p_busy_no_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wr_ready_o);
endmodule

// File: tb/test_pgload_ctrl.sv
`timescale 1ns/1ps
module test_pgload_ctrl;
  localparam int TO  = 100;
  localparam int NW  = 64;
  typedef logic [NW*16-1:0] img_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o;
  logic [19:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        tick_us_i = 1'b0;
  logic [5:0]  rd_idx_i = '0;
  logic [15:0] rd_data_o;
  logic        prog_start_o;
  logic [13:0] prog_page_o;
  logic        busy_o;
  logic        eng_done_i = 1'b0;
  logic        page_err_o;

  pgload_ctrl i_pgload_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .tick_us_i(tick_us_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .prog_start_o(prog_start_o), .prog_page_o(prog_page_o),
    .busy_o(busy_o), .eng_done_i(eng_done_i), .page_err_o(page_err_o)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  int empties = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tick generator: one cycle in three
  int tdiv = 0;
  always @(negedge clk) begin
    tick_us_i <= (tdiv == 2);
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
  end

  // scoreboard
  img_t        exp_img;
  img_t        img_q[$];
  logic [13:0] page_q[$];

  // monitor / engine model
  bit          p_arm = 0, p_good = 0, p_tick = 0, p_ready = 0, p_start = 0;
  bit          first = 1;
  logic [13:0] win_page = '0;
  int          tcnt = 0;
  int          done_cnt = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (p_arm) tcnt = 0;
      else if (p_good) tcnt = 0;
      else if (p_tick) tcnt++;

      if (p_start) chk(!prog_start_o, "R10", "start pulse width", prog_start_o, 0);

      if (prog_start_o) begin
        starts++;
        chk(tcnt == TO, "R9", "ticks from last load to start", tcnt, TO);
        chk(busy_o, "R10", "busy with start", busy_o, 1);
        if (page_q.size() == 0) begin
          chk(0, "R1", "unexpected program start", 1, 0);
        end else begin
          img_t        ei;
          logic [13:0] ep;
          int          bad;
          ei  = img_q.pop_front();
          ep  = page_q.pop_front();
          bad = 0;
          chk(prog_page_o == ep, "R7", "page address", prog_page_o, ep);
          for (int i = 0; i < NW; i++) begin
            rd_idx_i = 6'(i);
            #0.01;
            if (rd_data_o !== ei[i*16 +: 16]) begin
              if (bad == 0)
                $display("FAIL R3 word %0d: actual=%0h expected=%0h",
                         i, rd_data_o, ei[i*16 +: 16]);
              bad++;
            end
          end
          checks++;  // R3 R4 R5 R6 image compare
          if (bad != 0) errors++;
        end
        done_cnt = 4;
      end else if (p_ready && !wr_ready_o) begin
        empties++;
        chk(first && tcnt == TO, "R11", "empty window expiry ticks", tcnt, TO);
      end

      if (done_cnt > 0) begin
        done_cnt--;
        eng_done_i = (done_cnt == 0);
      end else begin
        eng_done_i = 1'b0;
      end

      p_start = prog_start_o;
      p_ready = wr_ready_o;
      p_tick  = tick_us_i;
      p_arm   = arm_i && !wr_ready_o && !busy_o;
      p_good  = 0;
      if (p_arm) first = 1;
      else if (wr_valid_i && wr_ready_o) begin
        if (first || wr_addr_i[19:6] == win_page) begin
          p_good   = 1;
          first    = 0;
          win_page = wr_addr_i[19:6];
        end
      end
    end
  end

  task automatic arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
  endtask

  task automatic wr(input logic [13:0] pg, input logic [5:0] off,
                    input logic [15:0] d, input bit track);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = {pg, off}; wr_data_i = d;
    while (!wr_ready_o) @(negedge clk);
    @(negedge clk);
    wr_valid_i = 1'b0;
    if (track) exp_img[off*16 +: 16] = d;
  endtask

  task automatic gap(input int ticks);
    repeat (ticks * 3) @(negedge clk);
  endtask

  task automatic finish_page(input logic [13:0] pg);
    img_q.push_back(exp_img);
    page_q.push_back(pg);
    wait (busy_o);
    @(negedge clk);
    chk(!wr_ready_o, "R12", "ready low while busy", wr_ready_o, 0);
    wait (!busy_o);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_ready_o && !busy_o && !prog_start_o && !page_err_o, "R1",
        "reset outputs", {wr_ready_o, busy_o, prog_start_o, page_err_o}, 0);
    chk(rd_data_o == 16'hFFFF, "R5", "blank after reset", rd_data_o, 16'hFFFF);

    // stray write before arm: stalled, never stored
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = {14'h123, 6'd7}; wr_data_i = 16'h1234;
    repeat (10) @(negedge clk);
    chk(!wr_ready_o, "R1", "ready low before arm", wr_ready_o, 0);
    wr_valid_i = 1'b0;

    // window A: any order, overwrite
    exp_img = '1;
    arm();
    chk(wr_ready_o, "R2", "ready after arm", wr_ready_o, 1);
    wr(14'h123, 6'd5,  16'hAAAA, 1);
    wr(14'h123, 6'd63, 16'h6363, 1);
    gap(40);
    wr(14'h123, 6'd0,  16'h0F0F, 1);
    wr(14'h123, 6'd5,  16'h5555, 1);   // R6 later write wins
    finish_page(14'h123);

    // window B: foreign page, arm during window, held write while busy
    exp_img = '1;
    arm();
    chk(!page_err_o, "R8", "error clear at window open", page_err_o, 0);
    wr(14'h3FFF, 6'd1, 16'h0101, 1);
    wr(14'h0001, 6'd2, 16'hDEAD, 0);
    chk(page_err_o, "R8", "error on foreign page", page_err_o, 1);
    arm();                               // R2 ignored mid-window
    chk(wr_ready_o, "R2", "window still open after arm", wr_ready_o, 1);
    wr(14'h3FFF, 6'd3, 16'h0303, 1);
    img_q.push_back(exp_img);
    page_q.push_back(14'h3FFF);
    wait (busy_o);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = {14'h3FFF, 6'd9}; wr_data_i = 16'h9999;
    repeat (2) @(negedge clk);
    chk(!wr_ready_o, "R12", "held write stalled while busy", wr_ready_o, 0);
    chk(page_err_o, "R8", "error sticky while busy", page_err_o, 1);
    wait (!busy_o);
    @(negedge clk);
    wr_valid_i = 1'b0;
    @(negedge clk);

    // window C: nothing loaded
    arm();
    chk(!page_err_o, "R8", "error cleared by new window", page_err_o, 0);
    wait (!wr_ready_o);
    repeat (4) @(negedge clk);
    chk(!busy_o && empties == 1, "R11", "empty window back to idle", empties, 1);
    chk(starts == 2, "R11", "no start for empty window", starts, 2);

    // window D: full page in reverse order with long gaps
    exp_img = '1;
    arm();
    for (int k = NW - 1; k >= 0; k--) begin
      wr(14'h2A5, 6'(k), 16'(k * 257) ^ 16'h5A00, 1);
      if (k % 16 == 0) gap(70);
    end
    finish_page(14'h2A5);
    chk(starts == 3 && page_q.size() == 0, "R4", "all pages handed over",
        starts, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule